// File: doc/BRIEF.md
# DMA Audio Sample Playback Engine

This block plays 8-bit PCM audio from a region of memory on its own. Software loads a 24-bit first address and a 24-bit stop address one byte at a time. It picks mono or stereo and one of four sample rates, then sets the run bit. The engine reads bytes in ascending order through a request/grant read port and keeps them in a small FIFO. On each rate tick it presents a left and a right sample. When the fetch pointer reaches the stop address, the engine pulses an interrupt. It then reloads the frame if repeat is set, and otherwise stops fetching and plays out what is already buffered.

The address window is half-open: bytes from the first address up to, but not including, the stop address are played. The first and stop addresses are copied into working registers at start and again at every loop boundary. Reprogramming them during playback therefore changes the next frame and leaves the current one alone. The memory port follows valid/ready rules. `mem_req` is the valid, and `mem_gnt` is the ready. A byte is transferred in every cycle where both are high, with `mem_rdata` sampled in that cycle. Once raised, `mem_req` and `mem_addr` hold until granted, unless software stops playback. The audio output is a strobe with no back-pressure, because the consumer is paced by the same rate ticks.

Top module: `dma_audio_player`

## Requirements
- R1: After reset, every register reads 0, and `mem_req`, `aud_valid`, `aud_underrun` and `frame_irq` are low.
- R2: Register map on `reg_addr`. 0 is control: bit0 run, bit1 repeat. 1 is mode: bit7 mono, bits1:0 rate code. 2/3/4 are the first-address high/middle/low bytes. 5/6/7 are the stop-address high/middle/low bytes. All of these read back what was written, except that control bit0 reads the live run state.
- R3: Writing control with bit0=1 while stopped latches both addresses, flushes the FIFO and starts fetching at the first address. Writing control with bit0=0 stops at once, discards buffered bytes and suppresses further strobes and requests.
- R4: Requests carry ascending addresses within [first, stop). A request is raised only while the FIFO (DEPTH bytes, a power of two) has room, so at most DEPTH bytes are fetched ahead of the output.
- R5: When the fetch pointer equals the working stop address, `frame_irq` pulses for one cycle. Without repeat, the run bit clears.
- R6: With repeat set, the pointer reloads from the programmed first/stop registers at each boundary, so a stop address written during playback takes effect at the next frame.
- R7: In stereo (mode bit7=0), each tick consumes two bytes: the earlier byte goes to `aud_left` and the later byte to `aud_right`.
- R8: In mono (mode bit7=1), each tick consumes one byte and drives it on both channels.
- R9: `aud_valid` strobes occur every DIV_R0/DIV_R1/DIV_R2/DIV_R3 clock cycles for rate codes 0/1/2/3. The first strobe comes one full interval after start.
- R10: A tick that finds too few bytes while running repeats the previous samples and sets `aud_underrun`. The flag stays set until the next start.
- R11: Registers 8/9/10 return the live fetch pointer as high/middle/low bytes.
- R12: After a non-repeating frame ends, samples still in the FIFO keep playing at the rate. Strobes then cease.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory read request (valid) |
| mem_addr | output | 24 | Byte address of the request |
| mem_gnt | input | 1 | Memory grant (ready); data accepted this cycle |
| mem_rdata | input | 8 | Read byte, valid with mem_gnt |
| aud_valid | output | 1 | One-cycle strobe per rate tick |
| aud_left | output | 8 | Left sample |
| aud_right | output | 8 | Right sample |
| aud_underrun | output | 1 | Sticky starvation flag |
| frame_irq | output | 1 | One-cycle end-of-frame pulse |

## Verification
The properties assume the first address never equals the stop address while repeat is on. Without that, the boundary would recur every cycle and the single-cycle interrupt pulse would not hold. The bench always programs frames of at least two bytes. The properties also assume that `mem_gnt` is only acted on while `mem_req` is high and that `mem_rdata` is valid with the grant. The bench memory model returns a computed byte for the presented address in the same cycle and raises the grant as a plain level, so it respects both. Grant is held low in some scenarios to starve the FIFO and to freeze the pointer for readback.

// File: rtl/dap_pkg.sv
package dap_pkg;
  localparam int ADDR_W     = 24;
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int RA_W       = 4;

  localparam logic [RA_W-1:0] REG_CTRL  = 4'd0;
  localparam logic [RA_W-1:0] REG_MODE  = 4'd1;
  localparam logic [RA_W-1:0] REG_BEG_H = 4'd2;
  localparam logic [RA_W-1:0] REG_FIN_H = 4'd5;
  localparam logic [RA_W-1:0] REG_POS_H = 4'd8;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic       mono;
    logic [1:0] rate;
  } mode_t;
endpackage

// File: rtl/dap_regs.sv
module dap_regs
  import dap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [RA_W-1:0] addr,
  input  logic [7:0]      wdata,
  input  logic            frame_stop,
  input  addr_t           cur_addr,
  output logic            run,
  output logic            loop_en,
  output mode_t           mode,
  output addr_t           beg_addr,
  output addr_t           fin_addr,
  output logic            start_cmd,
  output logic            stop_cmd,
  output logic [7:0]      rdata
);
  logic ctrl_wr;
  assign ctrl_wr   = wr && (addr == REG_CTRL);
  assign start_cmd = ctrl_wr && wdata[0] && !run;
  assign stop_cmd  = ctrl_wr && !wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      loop_en  <= 1'b0;
      mode     <= '0;
      beg_addr <= '0;
      fin_addr <= '0;
    end else begin
      if (frame_stop) run <= 1'b0;
      if (ctrl_wr) begin
        run     <= wdata[0];
        loop_en <= wdata[1];
      end
      if (wr && addr == REG_MODE) begin
        mode.mono <= wdata[7];
        mode.rate <= wdata[1:0];
      end
      for (int b = 0; b < ADDR_BYTES; b++) begin
        if (wr && addr == REG_BEG_H + RA_W'(b))
          beg_addr[(ADDR_BYTES-1-b)*8 +: 8] <= wdata;
        if (wr && addr == REG_FIN_H + RA_W'(b))
          fin_addr[(ADDR_BYTES-1-b)*8 +: 8] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == REG_CTRL) rdata = {6'b0, loop_en, run};
    if (addr == REG_MODE) rdata = {mode.mono, 5'b0, mode.rate};
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (addr == REG_BEG_H + RA_W'(b)) rdata = beg_addr[(ADDR_BYTES-1-b)*8 +: 8];
      if (addr == REG_FIN_H + RA_W'(b)) rdata = fin_addr[(ADDR_BYTES-1-b)*8 +: 8];
      if (addr == REG_POS_H + RA_W'(b)) rdata = cur_addr[(ADDR_BYTES-1-b)*8 +: 8];
    end
  end
endmodule

// File: rtl/dap_fetch.sv
module dap_fetch
  import dap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_cmd,
  input  logic  run,
  input  logic  loop_en,
  input  addr_t beg_addr,
  input  addr_t fin_addr,
  input  logic  room,
  input  logic  mem_gnt,
  output logic  mem_req,
  output addr_t cur_addr,
  output logic  push,
  output logic  boundary,
  output logic  frame_stop,
  output logic  frame_irq
);
  addr_t fin_w;

  assign boundary   = run && (cur_addr == fin_w);
  assign frame_stop = boundary && !loop_en;
  assign mem_req    = run && (cur_addr != fin_w) && room;
  assign push       = mem_req && mem_gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      fin_w     <= '0;
      frame_irq <= 1'b0;
    end else begin
      frame_irq <= boundary;
      if (start_cmd || (boundary && loop_en)) begin
        cur_addr <= beg_addr;
        fin_w    <= fin_addr;
      end else if (push) begin
        cur_addr <= cur_addr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dap_fifo.sv
module dap_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic [1:0]    pop,
  output logic [W-1:0]  head0,
  output logic [W-1:0]  head1,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  assign head0 = mem[rp];
  assign head1 = mem[rp + 1'b1];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      rp    <= rp + PW'(pop);
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/dap_rate.sv
module dap_rate #(
  parameter int DIV_R0 = 8000,
  parameter int DIV_R1 = 4000,
  parameter int DIV_R2 = 2000,
  parameter int DIV_R3 = 1000,
  localparam int M01  = (DIV_R0 > DIV_R1) ? DIV_R0 : DIV_R1,
  localparam int M23  = (DIV_R2 > DIV_R3) ? DIV_R2 : DIV_R3,
  localparam int MAXD = (M01 > M23) ? M01 : M23,
  localparam int CW   = $clog2(MAXD + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       active,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [CW-1:0] cnt, reload;

  always_comb begin
    case (rate)
      2'd0:    reload = CW'(DIV_R0 - 1);
      2'd1:    reload = CW'(DIV_R1 - 1);
      2'd2:    reload = CW'(DIV_R2 - 1);
      default: reload = CW'(DIV_R3 - 1);
    endcase
  end

  assign tick = active && !restart && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                                   cnt <= '0;
    else if (restart || !active || cnt == '0)     cnt <= reload;
    else                                          cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/dap_out.sv
module dap_out #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          mono,
  input  logic [CW-1:0] fifo_cnt,
  input  logic [7:0]    head0,
  input  logic [7:0]    head1,
  input  logic          clr_underrun,
  output logic [1:0]    pop,
  output logic          active,
  output logic          aud_valid,
  output logic [7:0]    aud_left,
  output logic [7:0]    aud_right,
  output logic          underrun
);
  logic [1:0] need;
  logic       have;

  assign need   = mono ? 2'd1 : 2'd2;
  assign have   = fifo_cnt >= CW'(need);
  assign active = run || have;
  assign pop    = (tick && have) ? need : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aud_valid <= 1'b0;
      aud_left  <= '0;
      aud_right <= '0;
      underrun  <= 1'b0;
    end else begin
      aud_valid <= tick;
      if (tick && have) begin
        aud_left  <= head0;
        aud_right <= mono ? head0 : head1;
      end
      if (clr_underrun)               underrun <= 1'b0;
      else if (tick && !have && run)  underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_audio_player.sv
module dma_audio_player
  import dap_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DIV_R0 = 8000,
  parameter int DIV_R1 = 4000,
  parameter int DIV_R2 = 2000,
  parameter int DIV_R3 = 1000,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata,
  output logic              aud_valid,
  output logic [7:0]        aud_left,
  output logic [7:0]        aud_right,
  output logic              aud_underrun,
  output logic              frame_irq
);
  logic          run, loop_en, start_cmd, stop_cmd;
  mode_t         mode;
  addr_t         beg_addr, fin_addr, cur_addr;
  logic          room, push, boundary, frame_stop;
  logic [CW-1:0] fifo_count;
  logic [7:0]    head0, head1;
  logic [1:0]    pop;
  logic          active, tick;

  assign room     = fifo_count < CW'(DEPTH);
  assign mem_addr = cur_addr;

  dap_regs u_regs (
    .clk, .rst_n, .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .frame_stop, .cur_addr, .run, .loop_en, .mode, .beg_addr, .fin_addr,
    .start_cmd, .stop_cmd, .rdata(reg_rdata)
  );

  dap_fetch u_fetch (
    .clk, .rst_n, .start_cmd, .run, .loop_en, .beg_addr, .fin_addr,
    .room, .mem_gnt, .mem_req, .cur_addr, .push, .boundary,
    .frame_stop, .frame_irq
  );

  dap_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk, .rst_n, .flush(start_cmd || stop_cmd), .push, .din(mem_rdata),
    .pop, .head0, .head1, .count(fifo_count)
  );

  dap_rate #(.DIV_R0(DIV_R0), .DIV_R1(DIV_R1), .DIV_R2(DIV_R2), .DIV_R3(DIV_R3)) u_rate (
    .clk, .rst_n, .restart(start_cmd), .active, .rate(mode.rate), .tick
  );

  dap_out #(.CW(CW)) u_out (
    .clk, .rst_n, .tick, .run, .mono(mode.mono), .fifo_cnt(fifo_count),
    .head0, .head1, .clr_underrun(start_cmd), .pop, .active,
    .aud_valid, .aud_left, .aud_right, .underrun(aud_underrun)
  );
endmodule

// File: rtl/dap_checker.sv
module dap_checker #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic [23:0]   mem_addr,
  input logic [CW-1:0] fifo_cnt,
  input logic          run,
  input logic          loop_en,
  input logic          mono,
  input logic          boundary,
  input logic          start_cmd,
  input logic          stop_cmd,
  input logic          frame_irq,
  input logic          aud_valid,
  input logic [7:0]    aud_left,
  input logic [7:0]    aud_right,
  input logic          underrun
);
  AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> run); // R3

  AST_REQ_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (fifo_cnt < CW'(DEPTH))); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !stop_cmd) |=> (mem_req && $stable(mem_addr))); // R4

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq); // R5

  AST_END_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !loop_en && !reg_wr) |=> !run); // R5

  AST_MONO_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (aud_valid && $past(mono) && ($past(fifo_cnt) != '0)) |-> (aud_left == aud_right)); // R8

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !start_cmd) |=> underrun); // R10
endmodule

bind dma_audio_player dap_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .mem_req(mem_req),
  .mem_gnt(mem_gnt), .mem_addr(mem_addr), .fifo_cnt(fifo_count),
  .run(run), .loop_en(loop_en), .mono(mode.mono), .boundary(boundary),
  .start_cmd(start_cmd), .stop_cmd(stop_cmd), .frame_irq(frame_irq),
  .aud_valid(aud_valid), .aud_left(aud_left), .aud_right(aud_right),
  .underrun(aud_underrun)
);

// File: tb/dma_audio_player_test.sv
`timescale 1ns/1ps
module dma_audio_player_test;
  localparam int D0 = 40, D1 = 28, D2 = 20, D3 = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic mem_req, mem_gnt, aud_valid, aud_underrun, frame_irq;
  logic [23:0] mem_addr;
  logic [7:0] mem_rdata, aud_left, aud_right;
  logic gnt_en = 1'b1;

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign mem_gnt   = gnt_en;
  assign mem_rdata = mem_req ? pat(mem_addr) : 8'h00;

  dma_audio_player #(.DEPTH(8), .DIV_R0(D0), .DIV_R1(D1), .DIV_R2(D2), .DIV_R3(D3)) uut (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req, .mem_addr, .mem_gnt, .mem_rdata,
    .aud_valid, .aud_left, .aud_right, .aud_underrun, .frame_irq
  );

  int total = 0, fails = 0, cyc = 0;
  int ncap = 0, nirq = 0, ngnt = 0, nbad = 0;
  logic [23:0] win_lo = '0, win_hi = 24'hFFFFFF;
  logic [7:0] cap_l [64];
  logic [7:0] cap_r [64];
  int cap_t [64];

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (aud_valid) begin
      if (ncap < 64) begin
        cap_l[ncap] = aud_left; cap_r[ncap] = aud_right; cap_t[ncap] = cyc;
      end
      ncap++;
    end
    if (frame_irq) nirq++;
    if (mem_req && mem_gnt) begin
      ngnt++;
      if (mem_addr < win_lo || mem_addr >= win_hi) nbad++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic set_frame(input logic [23:0] b, input logic [23:0] e);
    wr_reg(4'd2, b[23:16]); wr_reg(4'd3, b[15:8]); wr_reg(4'd4, b[7:0]);
    wr_reg(4'd5, e[23:16]); wr_reg(4'd6, e[15:8]); wr_reg(4'd7, e[7:0]);
    win_lo = b; win_hi = e;
  endtask

  task automatic clear_mon();
    @(negedge clk); #2;
    ncap = 0; nirq = 0; ngnt = 0; nbad = 0;
  endtask

  task automatic wait_caps(input int n, input int lim);
    for (int i = 0; i < lim && ncap < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    check(!mem_req && !aud_valid && !aud_underrun && !frame_irq, "R1", "outputs after reset",
          {mem_req, aud_valid, aud_underrun, frame_irq}, 0);
    for (int a = 0; a < 11; a++) begin
      rd_reg(4'(a), d);
      check(d == 8'h00, "R1", $sformatf("reg %0d after reset", a), d, 0);
    end
  endtask

  task automatic t_stereo_oneshot();
    logic [7:0] d;
    gnt_en = 1'b1;
    set_frame(24'h000100, 24'h000108);
    wr_reg(4'd1, 8'h03);
    clear_mon();
    wr_reg(4'd0, 8'h01);
    wait_caps(4, 200);
    repeat (60) @(negedge clk);
    check(ncap == 4, "R12", "stereo pairs played after frame end", ncap, 4);
    for (int i = 0; i < 4; i++) begin
      check(cap_l[i] == pat(24'h100 + 24'(2*i)), "R7", "left sample", cap_l[i], pat(24'h100 + 24'(2*i)));
      check(cap_r[i] == pat(24'h101 + 24'(2*i)), "R7", "right sample", cap_r[i], pat(24'h101 + 24'(2*i)));
    end
    check(cap_t[1] - cap_t[0] == D3, "R9", "rate 3 interval", cap_t[1] - cap_t[0], D3);
    check(nirq == 1, "R5", "frame interrupts", nirq, 1);
    check(ngnt == 8 && nbad == 0, "R4", "grants in window", ngnt + 100*nbad, 8);
    rd_reg(4'd0, d);
    check(d[0] == 1'b0, "R5", "run cleared at frame end", d, 0);
    check(!aud_underrun, "R10", "no underrun with ready memory", aud_underrun, 0);
  endtask

  task automatic t_mono_loop();
    logic [7:0] d;
    logic [7:0] exp_lo [8] = '{8'h00, 8'h01, 8'h00, 8'h01, 8'h02, 8'h03, 8'h00, 8'h01};
    gnt_en = 1'b0;
    set_frame(24'h000300, 24'h000302);
    win_hi = 24'h000304;
    wr_reg(4'd1, 8'h81);
    clear_mon();
    wr_reg(4'd0, 8'h03);
    wr_reg(4'd7, 8'h04);
    @(negedge clk); gnt_en = 1'b1;
    wait_caps(8, 400);
    check(ncap >= 8, "R6", "looped samples count", ncap, 8);
    for (int i = 0; i < 8; i++) begin
      check(cap_l[i] == pat(24'h300 | 24'(exp_lo[i])), "R6", "looped sample order",
            cap_l[i], pat(24'h300 | 24'(exp_lo[i])));
      check(cap_l[i] == cap_r[i], "R8", "mono on both channels", cap_r[i], cap_l[i]);
    end
    check(cap_t[1] - cap_t[0] == D1, "R9", "rate 1 interval", cap_t[1] - cap_t[0], D1);
    check(nirq >= 2 && nbad == 0, "R6", "loop boundaries and window", nirq + 100*nbad, 2);
    wr_reg(4'd0, 8'h00);
    clear_mon();
    repeat (100) @(negedge clk);
    check(ncap == 0 && ngnt == 0, "R3", "no activity after stop", ncap + ngnt, 0);
    rd_reg(4'd0, d);
    check(d == 8'h00, "R3", "control after stop", d, 0);
  endtask

  task automatic t_rates();
    int divs [4] = '{D0, D1, D2, D3};
    gnt_en = 1'b1;
    set_frame(24'h000400, 24'h0004F0);
    for (int c = 0; c < 4; c++) begin
      wr_reg(4'd1, 8'h80 | 8'(c));
      clear_mon();
      wr_reg(4'd0, 8'h01);
      if (c == 0) begin
        repeat (30) @(negedge clk);
        check(ngnt == 8 && !mem_req, "R4", "fetch stops at FIFO depth", ngnt, 8);
      end
      wait_caps(3, 200);
      check(cap_t[0] - cap_t[0] == 0 && cap_t[1] - cap_t[0] == divs[c], "R9",
            $sformatf("rate %0d interval", c), cap_t[1] - cap_t[0], divs[c]);
      check(cap_t[2] - cap_t[1] == divs[c], "R9", "rate steady interval", cap_t[2] - cap_t[1], divs[c]);
      check(cap_l[0] == pat(24'h400), "R3", "first sample from first address", cap_l[0], pat(24'h400));
      wr_reg(4'd0, 8'h00);
    end
  endtask

  task automatic t_underrun();
    logic [7:0] pl, pr;
    pl = aud_left; pr = aud_right;
    gnt_en = 1'b0;
    set_frame(24'h000500, 24'h000510);
    wr_reg(4'd1, 8'h03);
    clear_mon();
    wr_reg(4'd0, 8'h01);
    wait_caps(1, 100);
    check(aud_underrun == 1'b1, "R10", "underrun on empty FIFO", aud_underrun, 1);
    check(cap_l[0] == pl && cap_r[0] == pr, "R10", "previous sample repeated", {cap_l[0], cap_r[0]}, {pl, pr});
    gnt_en = 1'b1;
    wait_caps(2, 100);
    check(cap_l[1] == pat(24'h500) && cap_r[1] == pat(24'h501), "R7", "pair after recovery",
          {cap_l[1], cap_r[1]}, {pat(24'h500), pat(24'h501)});
    check(aud_underrun == 1'b1, "R10", "underrun sticky", aud_underrun, 1);
    wr_reg(4'd0, 8'h00);
    wr_reg(4'd0, 8'h01);
    check(aud_underrun == 1'b0, "R10", "underrun cleared at start", aud_underrun, 0);
    wr_reg(4'd0, 8'h00);
  endtask

  task automatic t_position();
    logic [7:0] d;
    logic [7:0] exp [11] = '{8'h01, 8'h00, 8'hAB, 8'hCD, 8'hEF, 8'hAB, 8'hCE, 8'h10, 8'hAB, 8'hCD, 8'hEF};
    gnt_en = 1'b0;
    set_frame(24'hABCDEF, 24'hABCE10);
    wr_reg(4'd1, 8'h00);
    wr_reg(4'd0, 8'h01);
    for (int a = 0; a < 11; a++) begin
      rd_reg(4'(a), d);
      check(d == exp[a], a >= 8 ? "R11" : "R2", $sformatf("readback reg %0d", a), d, exp[a]);
    end
    @(negedge clk); gnt_en = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk); gnt_en = 1'b0;
    rd_reg(4'd10, d);
    check(d == 8'hF2, "R11", "live pointer low byte", d, 8'hF2);
    wr_reg(4'd0, 8'h00);
    gnt_en = 1'b1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stereo_oneshot();
    t_mono_loop();
    t_rates();
    t_underrun();
    t_position();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual %0d expected completion", cyc);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule